// File: doc/BRIEF.md
# GPIO Pad Output Controller

This block drives the output side of a bank of general-purpose pins (50 by default). For every pin it holds one stored output value bit and one stored drive-enable bit. It also holds a small per-pin configuration: a function select, a 2-bit output mode, and pull and drive-strength fields that are stored and passed on to the pad ring without being interpreted. The value and enable banks are grouped into 32-bit words. Software changes them through set, clear and toggle masks applied to one selected word per cycle, so a single pin can change without a read-modify-write. Either bank can be read back one word at a time.

The per-pin output mode turns the stored bits into a pad output level and a pad output enable. Push-pull drives the stored value. Open-drain only ever pulls low. Tristate drives the value only while the pin's enable bit is set. Disabled never drives. A pin belongs to this data path only when its function select holds the GPIO code. If it does not, the pin's value and enable bits refuse writes and the block never drives the pad.

Top module: `gpio_pad_out_ctrl`

## Requirements
- R1: After reset every stored value bit and enable bit is 0, every function select is 0 and every output mode is 0, so no pad output enable is asserted.
- R2: Pin n maps to word n/32 (word index = bit 5 of n) at bit n mod 32, for set, clear and toggle masks and for readback; a mask write takes effect at the next clock edge.
- R3: A 1 in a set mask sets the bit and a 1 in a clear mask clears it; when both hit the same bit in the same cycle the bit ends at 0.
- R4: A 1 in a toggle mask inverts the bit, separately for the value bank and the enable bank; set and clear both take precedence over toggle on the same bit.
- R5: Set, clear and toggle requests to a pin whose 3-bit function select is not 3 leave its value and enable bits unchanged.
- R6: Output mode 0 (disabled) never asserts pad_oe; mode 1 (push-pull) asserts pad_oe and drives pad_out with the stored value; pad_out is 0 whenever pad_oe is 0.
- R7: Output mode 2 (open-drain) asserts pad_oe with pad_out 0 when the stored value is 0, and releases the pad when the value is 1.
- R8: Output mode 3 (tristate) drives the stored value only while the pin's enable bit is 1 and floats the pad while it is 0.
- R9: A pin whose function select is not 3 never has pad_oe asserted, whatever its mode and stored bits.
- R10: Bit positions past the last pin read back as 0 and ignore all writes; a configuration write naming a pin index past the last pin changes nothing.
- R11: A configuration write updates the addressed pin's function select, mode, pull field (3 bits at pad_pull[3n+2:3n]) and drive field (2 bits at pad_drive[2n+1:2n]) at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_word | input | SEL_W | Word targeted by the mask inputs this cycle |
| val_set | input | WORD_W | Set mask for the value bank |
| val_clr | input | WORD_W | Clear mask for the value bank |
| val_tgl | input | WORD_W | Toggle mask for the value bank |
| en_set | input | WORD_W | Set mask for the enable bank |
| en_clr | input | WORD_W | Clear mask for the enable bank |
| en_tgl | input | WORD_W | Toggle mask for the enable bank |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | PIN_W | Pin addressed by the configuration write |
| cfg_func | input | FUNC_W | Function select to store |
| cfg_mode | input | 2 | Output mode to store (0 off, 1 push-pull, 2 open-drain, 3 tristate) |
| cfg_pull | input | PULL_W | Pull setting to store |
| cfg_drive | input | DRIVE_W | Drive strength setting to store |
| rd_word | input | SEL_W | Word selected for readback |
| rd_val | output | WORD_W | Value bank word selected by rd_word |
| rd_en | output | WORD_W | Enable bank word selected by rd_word |
| pad_out | output | NUM_PINS | Per-pin output level to the pad |
| pad_oe | output | NUM_PINS | Per-pin output enable to the pad |
| pad_pull | output | NUM_PINS*PULL_W | Stored pull fields, PULL_W bits per pin |
| pad_drive | output | NUM_PINS*DRIVE_W | Stored drive fields, DRIVE_W bits per pin |

## Verification
The bench builds the block with its default values: 50 pins over two 32-bit words. This leaves the upper word only partly filled, with 18 live bits and 14 dead ones. That shape puts the dead bit positions, the word-to-pin mapping across the word boundary, and an out-of-range pin index (which still fits the 6-bit pin field) all within the bench's reach. Every pin is configured once, so rejection by function select can be seen on one pin while its neighbours in the same word still accept the same mask.

// File: rtl/gpio_pad_out_ctrl.sv
module gpio_pad_out_ctrl #(
  parameter int NUM_PINS  = 50,
  parameter int WORD_W    = 32,
  parameter int FUNC_W    = 3,
  parameter int GPIO_FUNC = 3,
  parameter int PULL_W    = 3,
  parameter int DRIVE_W   = 2,
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SEL_W-1:0]            wr_word,
  input  logic [WORD_W-1:0]           val_set,
  input  logic [WORD_W-1:0]           val_clr,
  input  logic [WORD_W-1:0]           val_tgl,
  input  logic [WORD_W-1:0]           en_set,
  input  logic [WORD_W-1:0]           en_clr,
  input  logic [WORD_W-1:0]           en_tgl,
  input  logic                        cfg_we,
  input  logic [PIN_W-1:0]            cfg_pin,
  input  logic [FUNC_W-1:0]           cfg_func,
  input  logic [1:0]                  cfg_mode,
  input  logic [PULL_W-1:0]           cfg_pull,
  input  logic [DRIVE_W-1:0]          cfg_drive,
  input  logic [SEL_W-1:0]            rd_word,
  output logic [WORD_W-1:0]           rd_val,
  output logic [WORD_W-1:0]           rd_en,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe,
  output logic [NUM_PINS*PULL_W-1:0]  pad_pull,
  output logic [NUM_PINS*DRIVE_W-1:0] pad_drive
);

  localparam int SPAN = (1 << SEL_W) * WORD_W;
  localparam logic [1:0] M_OFF = 2'd0;
  localparam logic [1:0] M_PP  = 2'd1;
  localparam logic [1:0] M_OD  = 2'd2;
  localparam logic [1:0] M_TRI = 2'd3;
  localparam logic [SPAN-1:0] LIVE = SPAN'({NUM_PINS{1'b1}});

  function automatic logic [NUM_PINS-1:0] spread(input logic [SEL_W-1:0] w,
                                                 input logic [WORD_W-1:0] m);
    logic [SPAN-1:0] t;
    t = '0;
    t[w*WORD_W +: WORD_W] = m;
    return t[NUM_PINS-1:0];
  endfunction

  logic [NUM_PINS-1:0] val_q, en_q, own;
  logic [NUM_PINS-1:0] vs_raw, vc_raw;
  logic [NUM_PINS-1:0] vs, vc, vt, es, ec, et;
  logic [SPAN-1:0]     val_x, en_x;

  assign vs_raw = spread(wr_word, val_set);
  assign vc_raw = spread(wr_word, val_clr);
  assign vs = vs_raw & own;
  assign vc = vc_raw & own;
  assign vt = spread(wr_word, val_tgl) & own;
  assign es = spread(wr_word, en_set) & own;
  assign ec = spread(wr_word, en_clr) & own;
  assign et = spread(wr_word, en_tgl) & own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      en_q  <= '0;
    end else begin
      val_q <= ((val_q ^ vt) | vs) & ~vc;
      en_q  <= ((en_q ^ et) | es) & ~ec;
    end
  end

  assign val_x  = SPAN'(val_q);
  assign en_x   = SPAN'(en_q);
  assign rd_val = val_x[rd_word*WORD_W +: WORD_W];
  assign rd_en  = en_x[rd_word*WORD_W +: WORD_W];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [FUNC_W-1:0]  func_q;
    logic [1:0]         mode_q;
    logic [PULL_W-1:0]  pull_q;
    logic [DRIVE_W-1:0] drv_q;
    logic               drive;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        func_q <= '0;
        mode_q <= M_OFF;
        pull_q <= '0;
        drv_q  <= '0;
      end else if (cfg_we && cfg_pin == PIN_W'(i)) begin
        func_q <= cfg_func;
        mode_q <= cfg_mode;
        pull_q <= cfg_pull;
        drv_q  <= cfg_drive;
      end
    end

    assign own[i] = (func_q == FUNC_W'(GPIO_FUNC));

    always_comb begin
      case (mode_q)
        M_PP:    drive = 1'b1;
        M_OD:    drive = ~val_q[i];
        M_TRI:   drive = en_q[i];
        default: drive = 1'b0;
      endcase
    end

    assign pad_oe[i]  = own[i] & drive;
    assign pad_out[i] = pad_oe[i] & (mode_q != M_OD) & val_q[i];
    assign pad_pull[i*PULL_W +: PULL_W]    = pull_q;
    assign pad_drive[i*DRIVE_W +: DRIVE_W] = drv_q;

    p_reject_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !own[i] |=> $stable(val_q[i]));
    p_reject_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !own[i] |=> $stable(en_q[i]));
    p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (own[i] && vs_raw[i] && vc_raw[i]) |=> !val_q[i]);
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[i] |-> !pad_out[i]);
    p_od_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_OD) |-> !pad_out[i]);
    p_tri_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_TRI && !en_q[i]) |-> !pad_oe[i]);
    p_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !own[i] |-> !pad_oe[i]);
  end

  p_dead_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_val | rd_en) & ~LIVE[rd_word*WORD_W +: WORD_W]) == '0);

endmodule

// File: tb/sim_gpio_pad_out_ctrl.sv
module sim_gpio_pad_out_ctrl;
  localparam int NP = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [0:0]  wr_word = '0, rd_word = '0;
  logic [31:0] val_set = '0, val_clr = '0, val_tgl = '0;
  logic [31:0] en_set = '0, en_clr = '0, en_tgl = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_pin = '0;
  logic [2:0]  cfg_func = '0;
  logic [1:0]  cfg_mode = '0;
  logic [2:0]  cfg_pull = '0;
  logic [1:0]  cfg_drive = '0;
  logic [31:0] rd_val, rd_en;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP*3-1:0] pad_pull;
  logic [NP*2-1:0] pad_drive;

  always #5 clk = ~clk;

  gpio_pad_out_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_word(wr_word),
    .val_set(val_set), .val_clr(val_clr), .val_tgl(val_tgl),
    .en_set(en_set), .en_clr(en_clr), .en_tgl(en_tgl),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_func(cfg_func), .cfg_mode(cfg_mode),
    .cfg_pull(cfg_pull), .cfg_drive(cfg_drive), .rd_word(rd_word),
    .rd_val(rd_val), .rd_en(rd_en), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull(pad_pull), .pad_drive(pad_drive)
  );

  typedef struct {
    int          kind;
    int          idx;
    logic [63:0] e0;
    logic [63:0] e1;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  logic [63:0] mval = '0, men = '0;
  int mfunc[NP], mmode[NP];

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int w, input logic [31:0] vs, vc, vt, es, ec, et);
    wr_word = w[0:0];
    val_set = vs; val_clr = vc; val_tgl = vt;
    en_set = es; en_clr = ec; en_tgl = et;
    tick();
    val_set = '0; val_clr = '0; val_tgl = '0;
    en_set = '0; en_clr = '0; en_tgl = '0;
    for (int b = 0; b < 32; b++) begin
      int p = w * 32 + b;
      if (p < NP && mfunc[p] == 3) begin
        mval[p] = ((mval[p] ^ vt[b]) | vs[b]) & ~vc[b];
        men[p]  = ((men[p] ^ et[b]) | es[b]) & ~ec[b];
      end
    end
  endtask

  task automatic cfg(input int pin, input int f, input int m, input int pl, input int dr);
    cfg_we = 1'b1; cfg_pin = pin[5:0]; cfg_func = f[2:0]; cfg_mode = m[1:0];
    cfg_pull = pl[2:0]; cfg_drive = dr[1:0];
    tick();
    cfg_we = 1'b0;
    if (pin < NP) begin mfunc[pin] = f; mmode[pin] = m; end
  endtask

  function automatic logic exp_oe(input int p);
    if (mfunc[p] != 3) return 1'b0;
    case (mmode[p])
      1: return 1'b1;
      2: return ~mval[p];
      3: return men[p];
      default: return 1'b0;
    endcase
  endfunction

  task automatic push(input int k, input int i, input logic [63:0] a, input logic [63:0] b, input string r);
    item_t it;
    it.kind = k; it.idx = i; it.e0 = a; it.e1 = b; it.req = r;
    q.push_back(it);
  endtask

  task automatic expect_rd(input int w, input string r);
    rd_word = w[0:0];
    push(0, w, {32'h0, mval[w*32 +: 32]}, {32'h0, men[w*32 +: 32]}, r);
    tick();
  endtask

  task automatic expect_pad(input int p, input string r);
    logic oe;
    oe = exp_oe(p);
    push(1, p, {63'h0, oe}, {63'h0, oe & (mmode[p] != 2) & mval[p]}, r);
    tick();
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] a0, a1;
      it = q.pop_front();
      a0 = '0; a1 = '0;
      case (it.kind)
        0: begin a0 = {32'h0, rd_val}; a1 = {32'h0, rd_en}; end
        1: begin a0 = {63'h0, pad_oe[it.idx]}; a1 = {63'h0, pad_out[it.idx]}; end
        2: begin a0 = {61'h0, pad_pull[it.idx*3 +: 3]}; a1 = {62'h0, pad_drive[it.idx*2 +: 2]}; end
        default: begin a0 = {14'h0, pad_oe}; a1 = {14'h0, pad_out}; end
      endcase
      checks++;
      if (a0 !== it.e0 || a1 !== it.e1) begin
        failures++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h/%h expected=%h/%h",
                 it.req, it.kind, it.idx, a0, a1, it.e0, it.e1);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin mfunc[p] = 0; mmode[p] = 0; end
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    expect_rd(0, "R1");
    expect_rd(1, "R1");
    push(3, 0, '0, '0, "R1"); tick();
    // R5: no pin owned yet, writes ignored
    wr(0, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, 0, 0);
    expect_rd(0, "R5");
    // R11: configure all pins; pin 7 is not GPIO
    for (int p = 0; p < NP; p++) cfg(p, (p == 7) ? 2 : 3, 1, p % 8, p % 4);
    push(2, 40, 64'd0, 64'd0, "R11"); tick();
    cfg(40, 3, 1, 5, 2);
    push(2, 40, 64'd5, 64'd2, "R11"); tick();
    // R2 / R5: full word set, pin 7 refuses
    wr(0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    expect_rd(0, "R5");
    // R10: upper word dead bits
    wr(1, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, 0, 0);
    expect_rd(1, "R10");
    cfg(60, 3, 2, 7, 3);
    expect_rd(1, "R10");
    push(3, 0, {14'h0, {NP{1'b1}}} & ~64'h80, {14'h0, mval[NP-1:0]} & ~64'h80, "R10"); tick();
    // R3: clear wins over set
    wr(0, 0, 32'hFFFF_FFFF, 0, 0, 32'hFFFF_FFFF, 0);
    wr(0, 32'h0000_00FF, 32'h0000_000F, 0, 32'h0000_0F00, 32'h0000_0300, 0);
    expect_rd(0, "R3");
    // R4: toggle, and set/clear beat toggle
    wr(0, 32'h0001_0000, 32'h0002_0000, 32'h0003_0F0F, 0, 0, 32'h0000_0003);
    expect_rd(0, "R4");
    wr(0, 0, 0, 32'h0000_00F0, 0, 0, 32'h0000_0F00);
    expect_rd(0, "R4");
    // R2: pin 33 lives in word 1 bit 1
    wr(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    wr(1, 32'h0000_0002, 0, 0, 0, 0, 0);
    expect_pad(33, "R2");
    expect_pad(32, "R2");
    // R6: push-pull and disabled
    wr(0, 32'h0000_0008, 32'h0000_0010, 0, 0, 0, 0);
    expect_pad(3, "R6");
    expect_pad(4, "R6");
    cfg(3, 3, 0, 0, 0);
    expect_pad(3, "R6");
    // R7: open-drain
    cfg(5, 3, 2, 0, 0);
    wr(0, 32'h0000_0020, 0, 0, 0, 0, 0);
    expect_pad(5, "R7");
    wr(0, 0, 32'h0000_0020, 0, 0, 0, 0);
    expect_pad(5, "R7");
    // R8: tristate
    cfg(6, 3, 3, 0, 0);
    wr(0, 32'h0000_0040, 0, 0, 0, 32'h0000_0040, 0);
    expect_pad(6, "R8");
    wr(0, 0, 0, 0, 32'h0000_0040, 0, 0);
    expect_pad(6, "R8");
    // R9: foreign function never drives
    expect_pad(7, "R9");
    cfg(7, 2, 3, 0, 0);
    wr(0, 32'h0000_0080, 0, 0, 32'h0000_0080, 0, 0);
    expect_pad(7, "R9");
    expect_rd(0, "R9");
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule